// File: doc/BRIEF.md
# Flash Status Auto-Polling Matcher

This block lets a flash controller wait for a status condition without software in the loop. Once started, it asks a serial engine for a status read through a request/acknowledge pair. It then collects the returned status bytes from a byte stream that marks its final byte. The collected word is masked and compared against a reference value in one of two logic modes. A match raises a sticky flag, which can drive an interrupt line.

Between reads the block idles for a programmable number of clock cycles. It can stop by itself on the first match, or keep polling until an abort. A typical use is waiting for a write-in-progress bit to clear after a program or erase. The serial pin timing belongs to the engine and is not part of this block.

Configuration inputs are sampled live and are expected to stay stable while the block is busy.

Top module: `statPoller`

## Requirements
- R1: After reset, `busy`, `cmdReq`, `matchFlag` and `matchIrq` are low and `statusWord` is zero.
- R2: A one-cycle `startReq` pulse while idle makes `busy` and `cmdReq` high after the next clock edge. `cmdReq` stays high until a cycle with `cmdAck` high. A `startReq` pulse while busy has no effect; in particular it does not shorten a running interval wait.
- R3: The first received byte of a read lands in bits 7:0, the second in 15:8, the third in 23:16 and the fourth in 31:24. `sizeSel` (0..3) selects 1..4 bytes to keep. Bytes beyond that count are discarded, and unfilled upper bytes read as zero. `statusWord` shows the new word from the edge that accepts the byte flagged by `rxLast`.
- R4: With `orMode` = 0, a read matches when every bit with `maskVal` = 1 equals the same bit of `matchVal`.
- R5: With `orMode` = 1, a read matches when at least one bit with `maskVal` = 1 equals the same bit of `matchVal`.
- R6: After the edge that accepts the last byte of a read that does not end polling, `cmdReq` stays low for exactly `intervalCycles` + 1 cycles. It is then high again.
- R7: With `autoStop` = 1, a matching read ends polling: `busy` falls on the second edge after the last byte, and no further request is made.
- R8: With `autoStop` = 0, a matching read sets the flag and polling goes on with a new request.
- R9: `matchFlag` is set on the second edge after the last byte of a matching read. It stays set until a cycle with `flagClr` high, and a set in the same cycle as a clear wins. `matchIrq` is high exactly when `matchFlag` and `irqEn` are both high.
- R10: An `abortReq` in any busy state drops `busy` and `cmdReq` after the next edge. No further request follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Start polling (pulse) |
| abortReq | input | 1 | Stop polling at once (pulse) |
| maskVal | input | 32 | Bits taking part in the comparison |
| matchVal | input | 32 | Reference value |
| orMode | input | 1 | 0: all masked bits must agree, 1: any masked bit |
| autoStop | input | 1 | End polling on the first match |
| sizeSel | input | 2 | Status bytes kept per read, minus one |
| intervalCycles | input | 16 | Idle cycles between reads |
| irqEn | input | 1 | Interrupt enable for the match flag |
| flagClr | input | 1 | Write-one-to-clear for the match flag |
| cmdReq | output | 1 | Status-read request to the serial engine |
| cmdAck | input | 1 | Engine accepted the request |
| rxValid | input | 1 | Received byte valid |
| rxByte | input | 8 | Received status byte |
| rxLast | input | 1 | Final byte of this read |
| busy | output | 1 | Polling active |
| matchFlag | output | 1 | Sticky status-match flag |
| matchIrq | output | 1 | Match interrupt request |
| statusWord | output | 32 | Last assembled status word |

## Verification
A wrong controller state shows at the ports almost at once. A missed stop leaves `busy` high, and a lost acknowledge leaves `cmdReq` stuck. A skipped or extra wait cycle moves the next rising edge of `cmdReq` off the `intervalCycles` + 1 mark, so the gap is measured cycle by cycle. A wrong byte index or byte counter corrupts `statusWord` on the edge that takes the last byte. A wrong comparison shows on `matchFlag` one edge later, so each mode is exercised with words that separate AND from OR behaviour.

// File: rtl/pollPkg.sv
package pollPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_RECV,
    ST_EVAL,
    ST_WAIT
  } pollState_t;

  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic clrShadow;
    logic takeByte;
    logic commit;
    logic evalNow;
    logic loadWait;
    logic tickWait;
  } pollStrobe_t;

endpackage

// File: rtl/pollData.sv
module pollData
  import pollPkg::*;
#(
  parameter int WORD_BYTES = 4,
  parameter int INTERVAL_W = 16,
  localparam int WORD_W = WORD_BYTES * 8,
  localparam int IDX_W = $clog2(WORD_BYTES)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  pollStrobe_t           stb,
  input  logic [WORD_W-1:0]     maskVal,
  input  logic [WORD_W-1:0]     matchVal,
  input  logic                  orMode,
  input  logic [IDX_W-1:0]      sizeSel,
  input  logic [INTERVAL_W-1:0] intervalCycles,
  input  logic                  irqEn,
  input  logic                  flagClr,
  input  logic [7:0]            rxByte,
  output logic                  matchHit,
  output logic                  intervalZero,
  output logic                  waitLast,
  output logic                  matchFlag,
  output logic                  matchIrq,
  output logic [WORD_W-1:0]     statusWord
);

  logic [WORD_W-1:0]     shadow;
  logic [WORD_W-1:0]     nextShadow;
  logic [WORD_W-1:0]     statusQ;
  logic [IDX_W:0]        byteIdx;
  logic [INTERVAL_W-1:0] waitCnt;
  logic                  flagQ;
  logic [WORD_W-1:0]     diffBits;
  logic                  allAgree;
  logic                  anyAgree;

  // Place the incoming byte into its lane when the lane is within size
  always_comb begin
    nextShadow = shadow;
    for (int b = 0; b < WORD_BYTES; b++) begin
      if ((byteIdx == (IDX_W+1)'(b)) && ((IDX_W+1)'(b) <= {1'b0, sizeSel}))
        nextShadow[b*8 +: 8] = rxByte;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadow  <= '0;
      byteIdx <= '0;
      statusQ <= '0;
    end else begin
      if (stb.clrShadow) begin
        shadow  <= '0;
        byteIdx <= '0;
      end else if (stb.takeByte) begin
        shadow <= nextShadow;
        if (byteIdx != (IDX_W+1)'(WORD_BYTES))
          byteIdx <= byteIdx + (IDX_W+1)'(1);
      end
      if (stb.commit)
        statusQ <= nextShadow;
    end
  end

  // Comparison: differing bits restricted by the mask
  assign diffBits = statusQ ^ matchVal;
  assign allAgree = ((diffBits & maskVal) == '0);
  assign anyAgree = |(~diffBits & maskVal);

  generate
    if (WORD_BYTES > 0) begin : g_cmp
      assign matchHit = orMode ? anyAgree : allAgree;
    end
  endgenerate

  // Interval counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      waitCnt <= '0;
    else if (stb.loadWait)
      waitCnt <= intervalCycles;
    else if (stb.tickWait)
      waitCnt <= waitCnt - INTERVAL_W'(1);
  end

  assign intervalZero = (intervalCycles == '0);
  assign waitLast     = (waitCnt == INTERVAL_W'(1));

  // Sticky match flag, set beats clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      flagQ <= 1'b0;
    else if (stb.evalNow && matchHit)
      flagQ <= 1'b1;
    else if (flagClr)
      flagQ <= 1'b0;
  end

  assign matchFlag  = flagQ;
  assign matchIrq   = flagQ & irqEn;
  assign statusWord = statusQ;

  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    flagQ && !flagClr |=> flagQ);

  p_flag_set_r9: assert property (@(posedge clk) disable iff (!rstN)
    stb.evalNow && matchHit |=> flagQ);

  p_wait_tick_r6: assert property (@(posedge clk) disable iff (!rstN)
    stb.tickWait |-> waitCnt != '0);

  p_upper_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    stb.commit && sizeSel == '0 && $stable(sizeSel) |=> statusQ[WORD_W-1:8] == '0);

endmodule

// File: rtl/pollCtrl.sv
module pollCtrl
  import pollPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic        abortReq,
  input  logic        autoStop,
  input  logic        cmdAck,
  input  logic        rxValid,
  input  logic        rxLast,
  input  logic        matchHit,
  input  logic        intervalZero,
  input  logic        waitLast,
  output logic        cmdReq,
  output logic        busy,
  output pollStrobe_t stb
);

  pollState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    stb       = '0;
    case (state)
      ST_IDLE: begin
        if (startReq) stateNext = ST_REQ;
      end
      ST_REQ: begin
        if (abortReq) stateNext = ST_IDLE;
        else if (cmdAck) begin
          stb.clrShadow = 1'b1;
          stateNext     = ST_RECV;
        end
      end
      ST_RECV: begin
        if (abortReq) stateNext = ST_IDLE;
        else if (rxValid) begin
          stb.takeByte = 1'b1;
          if (rxLast) begin
            stb.commit = 1'b1;
            stateNext  = ST_EVAL;
          end
        end
      end
      ST_EVAL: begin
        if (abortReq) stateNext = ST_IDLE;
        else begin
          stb.evalNow = 1'b1;
          if (matchHit && autoStop) stateNext = ST_IDLE;
          else if (intervalZero)    stateNext = ST_REQ;
          else begin
            stb.loadWait = 1'b1;
            stateNext    = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (abortReq) stateNext = ST_IDLE;
        else begin
          stb.tickWait = 1'b1;
          if (waitLast) stateNext = ST_REQ;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign cmdReq = (state == ST_REQ);
  assign busy   = (state != ST_IDLE);

  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    cmdReq && !cmdAck && !abortReq |=> cmdReq);

  p_abort_r10: assert property (@(posedge clk) disable iff (!rstN)
    abortReq && busy |=> !busy && !cmdReq);

  p_autostop_r7: assert property (@(posedge clk) disable iff (!rstN)
    stb.evalNow && matchHit && autoStop |=> !busy);

  p_keep_going_r8: assert property (@(posedge clk) disable iff (!rstN)
    stb.evalNow && !(matchHit && autoStop) |=> busy);

  p_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.clrShadow, stb.takeByte, stb.evalNow, stb.tickWait}));

endmodule

// File: rtl/statPoller.sv
module statPoller
  import pollPkg::*;
#(
  parameter int WORD_BYTES = 4,
  parameter int INTERVAL_W = 16,
  localparam int WORD_W = WORD_BYTES * 8,
  localparam int IDX_W = $clog2(WORD_BYTES)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  startReq,
  input  logic                  abortReq,
  input  logic [WORD_W-1:0]     maskVal,
  input  logic [WORD_W-1:0]     matchVal,
  input  logic                  orMode,
  input  logic                  autoStop,
  input  logic [IDX_W-1:0]      sizeSel,
  input  logic [INTERVAL_W-1:0] intervalCycles,
  input  logic                  irqEn,
  input  logic                  flagClr,
  output logic                  cmdReq,
  input  logic                  cmdAck,
  input  logic                  rxValid,
  input  logic [7:0]            rxByte,
  input  logic                  rxLast,
  output logic                  busy,
  output logic                  matchFlag,
  output logic                  matchIrq,
  output logic [WORD_W-1:0]     statusWord
);

  pollStrobe_t stb;
  logic        matchHit;
  logic        intervalZero;
  logic        waitLast;

  pollCtrl i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .startReq     (startReq),
    .abortReq     (abortReq),
    .autoStop     (autoStop),
    .cmdAck       (cmdAck),
    .rxValid      (rxValid),
    .rxLast       (rxLast),
    .matchHit     (matchHit),
    .intervalZero (intervalZero),
    .waitLast     (waitLast),
    .cmdReq       (cmdReq),
    .busy         (busy),
    .stb          (stb)
  );

  pollData #(
    .WORD_BYTES (WORD_BYTES),
    .INTERVAL_W (INTERVAL_W)
  ) i_data (
    .clk            (clk),
    .rstN           (rstN),
    .stb            (stb),
    .maskVal        (maskVal),
    .matchVal       (matchVal),
    .orMode         (orMode),
    .sizeSel        (sizeSel),
    .intervalCycles (intervalCycles),
    .irqEn          (irqEn),
    .flagClr        (flagClr),
    .rxByte         (rxByte),
    .matchHit       (matchHit),
    .intervalZero   (intervalZero),
    .waitLast       (waitLast),
    .matchFlag      (matchFlag),
    .matchIrq       (matchIrq),
    .statusWord     (statusWord)
  );

endmodule

// File: tb/test_statPoller.sv
module test_statPoller;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0, abortReq = 1'b0;
  logic [31:0] maskVal = '0, matchVal = '0;
  logic        orMode = 1'b0, autoStop = 1'b1;
  logic [1:0]  sizeSel = '0;
  logic [15:0] intervalCycles = '0;
  logic        irqEn = 1'b0, flagClr = 1'b0;
  logic        cmdReq, cmdAck = 1'b0;
  logic        rxValid = 1'b0, rxLast = 1'b0;
  logic [7:0]  rxByte = '0;
  logic        busy, matchFlag, matchIrq;
  logic [31:0] statusWord;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  statPoller i_statPoller (
    .clk(clk), .rstN(rstN), .startReq(startReq), .abortReq(abortReq),
    .maskVal(maskVal), .matchVal(matchVal), .orMode(orMode), .autoStop(autoStop),
    .sizeSel(sizeSel), .intervalCycles(intervalCycles), .irqEn(irqEn),
    .flagClr(flagClr), .cmdReq(cmdReq), .cmdAck(cmdAck), .rxValid(rxValid),
    .rxByte(rxByte), .rxLast(rxLast), .busy(busy), .matchFlag(matchFlag),
    .matchIrq(matchIrq), .statusWord(statusWord)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic startPoll();
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
  endtask

  task automatic pulseClr();
    flagClr = 1'b1;
    @(negedge clk);
    flagClr = 1'b0;
  endtask

  // Answer one request and deliver n bytes, LSB lane first; returns at the
  // falling edge right after the edge that accepted the last byte.
  task automatic serveRead(input logic [31:0] bytesLe, input int n);
    int guard = 0;
    while (!cmdReq && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
    cmdAck = 1'b1;
    @(negedge clk);
    cmdAck = 1'b0;
    for (int i = 0; i < n; i++) begin
      rxValid = 1'b1;
      rxByte  = bytesLe[i*8 +: 8];
      rxLast  = (i == n - 1);
      @(negedge clk);
    end
    rxValid = 1'b0;
    rxLast  = 1'b0;
  endtask

  task automatic t_reset();
    check(!busy && !cmdReq, "R1 busy/cmdReq", {busy, cmdReq}, 0);
    check(!matchFlag && !matchIrq, "R1 flag/irq", {matchFlag, matchIrq}, 0);
    check(statusWord == 0, "R1 statusWord", statusWord, 0);
  endtask

  task automatic t_andInterval();
    int k;
    maskVal = 32'h1; matchVal = 32'h0; orMode = 0; autoStop = 1;
    sizeSel = 0; intervalCycles = 16'd3;
    startPoll();
    check(busy && cmdReq, "R2 start", {busy, cmdReq}, 3);
    @(negedge clk); @(negedge clk);
    check(cmdReq, "R2 request held", cmdReq, 1);
    serveRead(32'h03, 1);
    check(statusWord == 32'h03, "R3 single byte", statusWord, 32'h03);
    k = 0;
    do begin
      startReq = (k == 2);
      @(negedge clk);
      k++;
    end while (!cmdReq && k < 100);
    startReq = 0;
    check(k == 4, "R6 gap interval=3 with start ignored", k, 4);
    check(!matchFlag, "R4 AND no match", matchFlag, 0);
    serveRead(32'h02, 1);
    @(negedge clk);
    check(matchFlag, "R4 AND match", matchFlag, 1);
    check(!busy, "R7 auto stop", busy, 0);
    k = 0;
    repeat (5) begin
      @(negedge clk);
      if (cmdReq) k++;
    end
    check(k == 0, "R7 no request after stop", k, 0);
  endtask

  task automatic t_flag();
    irqEn = 0;
    check(matchFlag && !matchIrq, "R9 irq masked", {matchFlag, matchIrq}, 2);
    irqEn = 1;
    #1;
    check(matchIrq, "R9 irq enabled", matchIrq, 1);
    pulseClr();
    check(!matchFlag && !matchIrq, "R9 clear", {matchFlag, matchIrq}, 0);
    maskVal = 0; intervalCycles = 0;
    startPoll();
    serveRead(32'h55, 1);
    flagClr = 1'b1;
    @(negedge clk);
    flagClr = 1'b0;
    check(matchFlag, "R9 set wins over clear", matchFlag, 1);
    pulseClr();
    irqEn = 0;
  endtask

  task automatic t_assembly();
    maskVal = 0; orMode = 0; autoStop = 1; sizeSel = 2'd1;
    startPoll();
    serveRead(32'h00332211, 3);
    check(statusWord == 32'h00002211, "R3 two bytes kept, third dropped", statusWord, 32'h00002211);
    @(negedge clk); @(negedge clk);
    sizeSel = 2'd3;
    startPoll();
    serveRead(32'hA1B2C3D4, 4);
    check(statusWord == 32'hA1B2C3D4, "R3 four byte order", statusWord, 32'hA1B2C3D4);
    @(negedge clk); @(negedge clk);
    pulseClr();
  endtask

  task automatic t_orMode();
    maskVal = 32'hF0; matchVal = 32'h80; orMode = 1; autoStop = 1;
    sizeSel = 0; intervalCycles = 0;
    startPoll();
    serveRead(32'h70, 1);
    @(negedge clk);
    check(!matchFlag && busy, "R5 OR no agreeing bit", {matchFlag, busy}, 1);
    serveRead(32'hF0, 1);
    @(negedge clk);
    check(matchFlag && !busy, "R5 OR one agreeing bit", {matchFlag, busy}, 2);
    pulseClr();
    orMode = 0;
    startPoll();
    serveRead(32'hF0, 1);
    @(negedge clk);
    check(!matchFlag && busy, "R4 AND rejects partial", {matchFlag, busy}, 1);
    abortReq = 1; @(negedge clk); abortReq = 0;
    check(!busy && !cmdReq, "R10 abort in request", {busy, cmdReq}, 0);
  endtask

  task automatic t_continuous();
    int k;
    maskVal = 0; orMode = 0; autoStop = 0; intervalCycles = 0; sizeSel = 0;
    startPoll();
    serveRead(32'h01, 1);
    @(negedge clk);
    check(matchFlag && busy && cmdReq, "R8 keeps polling after match",
          {matchFlag, busy, cmdReq}, 7);
    intervalCycles = 16'd10;
    serveRead(32'h01, 1);
    repeat (3) @(negedge clk);
    check(busy && !cmdReq, "R6 inside wait", {busy, cmdReq}, 2);
    abortReq = 1; @(negedge clk); abortReq = 0;
    check(!busy && !cmdReq, "R10 abort in wait", {busy, cmdReq}, 0);
    k = 0;
    repeat (15) begin
      @(negedge clk);
      if (cmdReq || busy) k++;
    end
    check(k == 0, "R10 no request after abort", k, 0);
    pulseClr();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_andInterval();
    t_flag();
    t_assembly();
    t_orMode();
    t_continuous();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule